// File: doc/BRIEF.md
# Register-Mapped Pad Crossbar with GPIO

This block is a bank of per-pad control registers sitting behind a simple byte-wide register bus, such as the register side of a serial target controller. Each pad has one 8-bit register. The register holds a 5-bit route code, a GPIO drive-enable bit and a GPIO data bit. On reads it also shows the synchronized level of the pad. From the route code, a combinational crossbar chooses what each pad drives and whether it drives at all. The choice is one of three: the pad's own GPIO bits, the synchronized input of another pad, or one of a set of internal function signals. Each function signal comes with a transmit-enable.

A few further routing registers pick which pad feeds each internal receive-side input, for example a serial receive line or a clear-to-send line. A route code that names no pad leaves that input at its idle level, logic 1. A push-switch input can be read at a fixed address. All pad inputs and the switch pass through a two-flop synchronizer before anything inside the block uses them. Tri-state buffers sit outside the block and are driven from the per-pad value and enable outputs.

Top module: `pin_xbar`

## Requirements
- R1: A pad register at address p (0 to N_PADS-1) has this layout: bit 0 is the GPIO drive-enable, bit 1 is the GPIO data, bit 2 is the read-only synchronized pad input, and bits 7:3 are the route code. Writes never change bit 2.
- R2: After reset, every pad register and routing register holds its own reset byte, taken from the PAD_RST and RX_RST parameters. The defaults are: pads 0..7 = F8, A1, 89, F8, 49, 11, F8, 29 (hex); routing registers 0..3 = 08, 20, F8, 40.
- R3: A write whose bits 7:3 are 0 leaves the stored route code unchanged. The same write still updates the GPIO data and drive-enable bits (pad registers) from bits 1:0.
- R4: With route code 31, the pad's pad_out equals its GPIO data bit and its pad_oe equals its GPIO drive-enable bit.
- R5: With route code k in 1..N_PADS, pad_out equals the synchronized input of pad k-1, and pad_oe equals the GPIO drive-enable bit.
- R6: With route code k in N_PADS+1..30, pad_out equals func_val[k-N_PADS-1], and pad_oe equals the GPIO drive-enable bit ANDed with func_en[k-N_PADS-1].
- R7: A change on pad_in or sw_in becomes visible on reads, on pad loopback and on rx_out exactly two rising clock edges later, and not after one.
- R8: Address SW_ADDR (default 31) reads the synchronized switch level in bit 0 and zeros in bits 7:1. Writes to that address have no effect.
- R9: Routing register j sits at address RX_BASE+j (default 32+j) and holds a route code in bits 7:3; its bits 2:0 read as 0. A code k in 1..N_PADS drives rx_out[j] from the synchronized input of pad k-1. Any other code drives rx_out[j] to 1. A written code of 0 keeps the stored code.
- R10: An address that maps to no register reads as 0, and a write to it changes no register and no output.
- R11: A write takes effect at the rising edge that samples bus_wr. pad_out and pad_oe follow in the same cycle, with no further register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pad_in | input | N_PADS | Raw pad input levels |
| pad_out | output | N_PADS | Value each pad drives |
| pad_oe | output | N_PADS | Drive enable per pad |
| sw_in | input | 1 | Raw push-switch level |
| func_val | input | 30-N_PADS | Internal function signals, indexed by route code minus N_PADS+1 |
| func_en | input | 30-N_PADS | Transmit enable belonging to each function signal |
| rx_out | output | N_RX | Routed receive-side inputs |

## Verification
Register writes show up on pad_out, pad_oe and on read-back one rising edge after bus_wr is sampled. The bench therefore drives each write at a falling edge and checks at the next falling edge. One test also samples just before and just after that rising edge. Pad, switch and loopback levels are due two rising edges after the input changes. The bench checks both the old value after one edge and the new value after two. Reads are combinational, so the bench samples bus_rdata one time unit after it sets the address, in the middle of a low clock phase.

// File: rtl/pxb_pkg.sv
package pxb_pkg;

    localparam int unsigned SEL_W = 5;

    typedef logic [SEL_W-1:0] sel_t;

    localparam sel_t CODE_KEEP = sel_t'(0);
    localparam sel_t CODE_GPIO = sel_t'(31);

    // Stored state of one pad register (bit 2 is not stored: it is the live input)
    typedef struct packed {
        sel_t sel;
        logic dout;
        logic oe;
    } pad_cfg_t;

    // Resolved drive of one pad
    typedef struct packed {
        logic drive;
        logic value;
    } pad_drv_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_PAD,
        SRC_FUNC,
        SRC_GPIO
    } src_kind_e;

    function automatic src_kind_e classify(sel_t s, int unsigned n_pads);
        if (s == CODE_GPIO) return SRC_GPIO;
        if (s == CODE_KEEP) return SRC_NONE;
        if (32'(s) <= n_pads) return SRC_PAD;
        return SRC_FUNC;
    endfunction

    function automatic pad_cfg_t cfg_from_byte(logic [7:0] b);
        pad_cfg_t c;
        c.sel  = b[7:3];
        c.dout = b[1];
        c.oe   = b[0];
        return c;
    endfunction

    function automatic sel_t next_sel(sel_t cur, logic [7:0] w);
        return (w[7:3] == CODE_KEEP) ? cur : w[7:3];
    endfunction

    function automatic pad_cfg_t merge_write(pad_cfg_t cur, logic [7:0] w);
        pad_cfg_t n;
        n.sel  = next_sel(cur.sel, w);
        n.dout = w[1];
        n.oe   = w[0];
        return n;
    endfunction

    function automatic logic [7:0] cfg_to_byte(pad_cfg_t c, logic din);
        return {c.sel, din, c.dout, c.oe};
    endfunction

endpackage

// File: rtl/pxb_sync.sv
module pxb_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;

endmodule

// File: rtl/pxb_regfile.sv
module pxb_regfile
    import pxb_pkg::*;
#(
    parameter int unsigned         N_PADS  = 8,
    parameter int unsigned         N_RX    = 4,
    parameter int unsigned         SW_ADDR = 31,
    parameter int unsigned         RX_BASE = 32,
    parameter logic [N_PADS*8-1:0] PAD_RST = '1,
    parameter logic [N_RX*8-1:0]   RX_RST  = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [N_PADS-1:0] pad_sync,
    input  logic              sw_sync,
    output pad_cfg_t          pad_cfg [N_PADS],
    output sel_t              rx_sel  [N_RX]
);

    pad_cfg_t cfg_q [N_PADS];
    sel_t     rx_q  [N_RX];

    // Pad registers
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(N_PADS); i++) begin
                cfg_q[i] <= cfg_from_byte(PAD_RST[i*8 +: 8]);
            end
        end else if (bus_wr) begin
            for (int i = 0; i < int'(N_PADS); i++) begin
                if (bus_addr == 8'(i)) begin
                    cfg_q[i] <= merge_write(cfg_q[i], bus_wdata);
                end
            end
        end
    end

    // Receive-routing registers
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < int'(N_RX); j++) begin
                rx_q[j] <= RX_RST[j*8+3 +: SEL_W];
            end
        end else if (bus_wr) begin
            for (int j = 0; j < int'(N_RX); j++) begin
                if (bus_addr == 8'(RX_BASE + j)) begin
                    rx_q[j] <= next_sel(rx_q[j], bus_wdata);
                end
            end
        end
    end

    // Read multiplexer: unmapped addresses fall through to zero
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < int'(N_PADS); i++) begin
            if (bus_addr == 8'(i)) begin
                bus_rdata = cfg_to_byte(cfg_q[i], pad_sync[i]);
            end
        end
        if (bus_addr == 8'(SW_ADDR)) begin
            bus_rdata = {7'b0, sw_sync};
        end
        for (int j = 0; j < int'(N_RX); j++) begin
            if (bus_addr == 8'(RX_BASE + j)) begin
                bus_rdata = {rx_q[j], 3'b000};
            end
        end
    end

    assign pad_cfg = cfg_q;
    assign rx_sel  = rx_q;

endmodule

// File: rtl/pxb_xbar.sv
module pxb_xbar
    import pxb_pkg::*;
#(
    parameter int unsigned N_PADS = 8,
    parameter int unsigned N_FUNC = 22
) (
    input  pad_cfg_t          cfg,
    input  logic [N_PADS-1:0] pad_sync,
    input  logic [N_FUNC-1:0] func_val,
    input  logic [N_FUNC-1:0] func_en,
    output pad_drv_t          drv
);

    always_comb begin
        drv = '0;
        unique case (classify(cfg.sel, N_PADS))
            SRC_GPIO: begin
                drv.value = cfg.dout;
                drv.drive = cfg.oe;
            end
            SRC_PAD: begin
                drv.drive = cfg.oe;
                for (int k = 0; k < int'(N_PADS); k++) begin
                    if (cfg.sel == sel_t'(k + 1)) begin
                        drv.value = pad_sync[k];
                    end
                end
            end
            SRC_FUNC: begin
                for (int k = 0; k < int'(N_FUNC); k++) begin
                    if (cfg.sel == sel_t'(k + int'(N_PADS) + 1)) begin
                        drv.value = func_val[k];
                        drv.drive = cfg.oe & func_en[k];
                    end
                end
            end
            default: drv = '0;
        endcase
    end

endmodule

// File: rtl/pxb_rxroute.sv
module pxb_rxroute
    import pxb_pkg::*;
#(
    parameter int unsigned N_PADS  = 8,
    parameter int unsigned N_RX    = 4,
    parameter logic        RX_IDLE = 1'b1
) (
    input  sel_t              rx_sel [N_RX],
    input  logic [N_PADS-1:0] pad_sync,
    output logic [N_RX-1:0]   rx_out
);

    for (genvar j = 0; j < int'(N_RX); j++) begin : g_rx
        always_comb begin
            rx_out[j] = RX_IDLE;
            if (classify(rx_sel[j], N_PADS) == SRC_PAD) begin
                for (int k = 0; k < int'(N_PADS); k++) begin
                    if (rx_sel[j] == sel_t'(k + 1)) begin
                        rx_out[j] = pad_sync[k];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
    import pxb_pkg::*;
#(
    parameter int unsigned         N_PADS  = 8,
    parameter int unsigned         N_RX    = 4,
    parameter int unsigned         SW_ADDR = 31,
    parameter int unsigned         RX_BASE = 32,
    parameter logic [N_PADS*8-1:0] PAD_RST = 64'h29F8_1149_F889_A1F8,
    parameter logic [N_RX*8-1:0]   RX_RST  = 32'h40F8_2008,
    localparam int unsigned        N_FUNC  = 30 - N_PADS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [N_PADS-1:0] pad_in,
    output logic [N_PADS-1:0] pad_out,
    output logic [N_PADS-1:0] pad_oe,
    input  logic              sw_in,
    input  logic [N_FUNC-1:0] func_val,
    input  logic [N_FUNC-1:0] func_en,
    output logic [N_RX-1:0]   rx_out
);

    logic [N_PADS-1:0] pad_sync;
    logic              sw_sync;
    pad_cfg_t          pad_cfg [N_PADS];
    sel_t              rx_sel  [N_RX];

    // Flattened configuration view for the checker
    logic [N_PADS*SEL_W-1:0] cfg_sel_flat;
    logic [N_PADS-1:0]       cfg_oe_vec;
    logic [N_PADS-1:0]       cfg_do_vec;

    pxb_sync #(
        .W (N_PADS + 1)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sw_in, pad_in}),
        .q   ({sw_sync, pad_sync})
    );

    pxb_regfile #(
        .N_PADS  (N_PADS),
        .N_RX    (N_RX),
        .SW_ADDR (SW_ADDR),
        .RX_BASE (RX_BASE),
        .PAD_RST (PAD_RST),
        .RX_RST  (RX_RST)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_sync  (pad_sync),
        .sw_sync   (sw_sync),
        .pad_cfg   (pad_cfg),
        .rx_sel    (rx_sel)
    );

    for (genvar i = 0; i < int'(N_PADS); i++) begin : g_pad
        pad_drv_t drv;

        pxb_xbar #(
            .N_PADS (N_PADS),
            .N_FUNC (N_FUNC)
        ) u_xbar (
            .cfg      (pad_cfg[i]),
            .pad_sync (pad_sync),
            .func_val (func_val),
            .func_en  (func_en),
            .drv      (drv)
        );

        assign pad_out[i] = drv.value;
        assign pad_oe[i]  = drv.drive;

        assign cfg_sel_flat[i*SEL_W +: SEL_W] = pad_cfg[i].sel;
        assign cfg_oe_vec[i]                  = pad_cfg[i].oe;
        assign cfg_do_vec[i]                  = pad_cfg[i].dout;
    end

    pxb_rxroute #(
        .N_PADS  (N_PADS),
        .N_RX    (N_RX),
        .RX_IDLE (1'b1)
    ) u_rx (
        .rx_sel   (rx_sel),
        .pad_sync (pad_sync),
        .rx_out   (rx_out)
    );

endmodule

// File: rtl/pin_xbar_chk.sv
module pin_xbar_chk #(
    parameter int unsigned         N_PADS  = 8,
    parameter int unsigned         N_RX    = 4,
    parameter int unsigned         SW_ADDR = 31,
    parameter int unsigned         RX_BASE = 32,
    parameter logic [N_PADS*8-1:0] PAD_RST = '1
) (
    input logic                clk,
    input logic                rst,
    input logic [7:0]          bus_addr,
    input logic                bus_wr,
    input logic [7:0]          bus_wdata,
    input logic [7:0]          bus_rdata,
    input logic [N_PADS-1:0]   pad_in,
    input logic [N_PADS-1:0]   pad_out,
    input logic [N_PADS-1:0]   pad_oe,
    input logic [N_PADS*5-1:0] cfg_sel_flat,
    input logic [N_PADS-1:0]   cfg_oe_vec,
    input logic [N_PADS-1:0]   cfg_do_vec
);

    // Cycles since reset release, saturating
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)             age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    logic mapped;
    assign mapped = (bus_addr < 8'(N_PADS)) || (bus_addr == 8'(SW_ADDR)) ||
                    ((bus_addr >= 8'(RX_BASE)) && (bus_addr < 8'(RX_BASE + N_RX)));

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> bus_rdata == 8'h00); // R10

    AST_SWITCH_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_addr == 8'(SW_ADDR) |-> bus_rdata[7:1] == 7'd0); // R8

    for (genvar i = 0; i < int'(N_PADS); i++) begin : g_chk
        AST_RESET_CFG: assert property (@(posedge clk) disable iff (rst)
            age == 2'd0 |-> (cfg_sel_flat[i*5 +: 5] == PAD_RST[i*8+3 +: 5]) &&
                            (cfg_do_vec[i] == PAD_RST[i*8+1]) &&
                            (cfg_oe_vec[i] == PAD_RST[i*8])); // R2

        AST_KEEP_SEL: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == 8'(i) && bus_wdata[7:3] == 5'd0)
            |=> cfg_sel_flat[i*5 +: 5] == $past(cfg_sel_flat[i*5 +: 5])); // R3

        AST_GPIO_WRITE: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == 8'(i) && bus_wdata[7:3] == 5'd31)
            |=> pad_out[i] == $past(bus_wdata[1]) && pad_oe[i] == $past(bus_wdata[0])); // R4

        AST_OE_GATE: assert property (@(posedge clk) disable iff (rst)
            !cfg_oe_vec[i] |-> !pad_oe[i]); // R6

        AST_SYNC_READ: assert property (@(posedge clk) disable iff (rst)
            (age >= 2'd2 && bus_addr == 8'(i)) |-> bus_rdata[2] == $past(pad_in[i], 2)); // R7
    end

endmodule

bind pin_xbar pin_xbar_chk #(
    .N_PADS  (N_PADS),
    .N_RX    (N_RX),
    .SW_ADDR (SW_ADDR),
    .RX_BASE (RX_BASE),
    .PAD_RST (PAD_RST)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pad_in       (pad_in),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .cfg_sel_flat (cfg_sel_flat),
    .cfg_oe_vec   (cfg_oe_vec),
    .cfg_do_vec   (cfg_do_vec)
);

// File: tb/test_pin_xbar.sv
module test_pin_xbar;

    localparam int NP = 8;
    localparam int NR = 4;
    localparam int NF = 30 - NP;
    localparam int SWA = 31;
    localparam int RXB = 32;
    localparam logic [NP*8-1:0] PAD_DEF = 64'h29F8_1149_F889_A1F8;
    localparam logic [NR*8-1:0] RX_DEF  = 32'h40F8_2008;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic          sw_in = 1'b0;
    logic [NF-1:0] func_val = 22'h2A5C3;
    logic [NF-1:0] func_en  = 22'h15F0F;
    logic [NR-1:0] rx_out;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // Expected register contents
    logic [4:0] esel [NP];
    logic       eoe  [NP];
    logic       edo  [NP];
    logic [4:0] erx  [NR];

    always #10 clk = ~clk;

    pin_xbar #(
        .N_PADS (NP), .N_RX (NR), .SW_ADDR (SWA), .RX_BASE (RXB),
        .PAD_RST (PAD_DEF), .RX_RST (RX_DEF)
    ) i_pin_xbar (
        .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .pad_in (pad_in),
        .pad_out (pad_out), .pad_oe (pad_oe), .sw_in (sw_in),
        .func_val (func_val), .func_en (func_en), .rx_out (rx_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [1:0] exp_drv(int p);
        int s = int'(esel[p]);
        if (s == 31) return {eoe[p], edo[p]};
        if (s >= 1 && s <= NP) return {eoe[p], pad_in[s-1]};
        if (s > NP && s <= 30) return {eoe[p] & func_en[s-NP-1], func_val[s-NP-1]};
        return 2'b00;
    endfunction

    function automatic logic exp_rx(int j);
        int s = int'(erx[j]);
        if (s >= 1 && s <= NP) return pad_in[s-1];
        return 1'b1;
    endfunction

    task automatic chk_pad(input string tag, input int p);
        logic [7:0] v;
        chk(tag, {pad_oe[p], pad_out[p]}, exp_drv(p));
        rd(8'(p), v);
        chk(tag, v, {esel[p], pad_in[p], edo[p], eoe[p]});
    endtask

    task automatic chk_all(input string tag);
        logic [7:0] v;
        for (int p = 0; p < NP; p++) chk_pad(tag, p);
        for (int j = 0; j < NR; j++) begin
            rd(8'(RXB + j), v);
            chk(tag, v, {erx[j], 3'b000});
            chk(tag, rx_out[j], exp_rx(j));
        end
    endtask

    task automatic wr_pad(input int p, input logic [7:0] d);
        wr(8'(p), d);
        if (d[7:3] != 5'd0) esel[p] = d[7:3];
        edo[p] = d[1];
        eoe[p] = d[0];
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int p = 0; p < NP; p++) begin
            esel[p] = PAD_DEF[p*8+3 +: 5];
            edo[p]  = PAD_DEF[p*8+1];
            eoe[p]  = PAD_DEF[p*8];
        end
        for (int j = 0; j < NR; j++) erx[j] = RX_DEF[j*8+3 +: 5];

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2: reset contents and the outputs they imply
        chk_all("R2 reset");
        rd(8'(SWA), v);
        chk("R2 switch reset", v, 8'h00);

        // R11: write visible right after the sampling edge, not before
        @(negedge clk);
        bus_addr = 8'd6; bus_wdata = 8'hFB; bus_wr = 1'b1;
        #1;
        chk("R11 before edge", {pad_oe[6], pad_out[6]}, 2'b00);
        @(posedge clk);
        #1;
        chk("R11 after edge", {pad_oe[6], pad_out[6]}, 2'b11);
        @(negedge clk);
        bus_wr = 1'b0;
        esel[6] = 5'd31; edo[6] = 1'b1; eoe[6] = 1'b1;

        // R4 / R1: GPIO sweep on every pad
        pad_in = 8'hA5;
        settle();
        for (int p = 0; p < NP; p++) begin
            for (int g = 0; g < 4; g++) begin
                wr_pad(p, {5'd31, 1'b0, 2'(g)});
                chk_pad("R4 gpio", p);
            end
        end

        // R5 / R6: every route code with both enables, on two pads
        for (int pi = 0; pi < 2; pi++) begin
            int p = (pi == 0) ? 0 : 5;
            for (int c = 1; c <= 30; c++) begin
                for (int oe = 0; oe < 2; oe++) begin
                    wr_pad(p, {5'(c), 1'b0, 1'b1, 1'(oe)});
                    if (c <= NP) chk_pad("R5 pad route", p);
                    else         chk_pad("R6 func route", p);
                end
            end
        end
        // R6 again with different function levels and enables
        func_val = ~func_val;
        func_en  = ~func_en;
        #1;
        for (int c = NP + 1; c <= 30; c++) begin
            wr_pad(3, {5'(c), 3'b001});
            chk_pad("R6 func inverted", 3);
        end

        // R3: code 0 keeps the route but updates the GPIO bits
        wr_pad(1, {5'd20, 3'b001});
        wr_pad(1, 8'h02);
        chk_pad("R3 keep route", 1);
        chk("R3 keep code", esel[1], 5'd20);
        wr_pad(1, 8'h05);
        chk_pad("R3 keep route 2", 1);

        // R1: bit 2 is read-only
        wr_pad(4, 8'hFC);
        chk_pad("R1 ro bit pad4", 4);
        wr_pad(0, 8'hF8);
        chk_pad("R1 ro bit pad0", 0);

        // R7: two-edge latency on read, loopback and receive routing
        wr_pad(7, {5'd5, 3'b001});
        @(negedge clk);
        pad_in = 8'h5A;
        @(negedge clk);
        rd(8'd4, v);
        chk("R7 one edge read", v[2], 1'b0);
        chk("R7 one edge loopback", pad_out[7], 1'b0);
        chk("R7 one edge rx", rx_out[0], 1'b1);
        @(negedge clk);
        rd(8'd4, v);
        chk("R7 two edge read", v[2], 1'b1);
        chk("R7 two edge loopback", pad_out[7], 1'b1);
        chk("R7 two edge rx", rx_out[0], 1'b0);

        // R8: switch register
        @(negedge clk);
        sw_in = 1'b1;
        @(negedge clk);
        rd(8'(SWA), v);
        chk("R8 switch one edge", v, 8'h00);
        @(negedge clk);
        rd(8'(SWA), v);
        chk("R8 switch set", v, 8'h01);
        wr(8'(SWA), 8'hFE);
        rd(8'(SWA), v);
        chk("R8 switch write ignored", v, 8'h01);
        sw_in = 1'b0;
        settle();
        rd(8'(SWA), v);
        chk("R8 switch clear", v, 8'h00);
        chk_all("R8 no side effect");

        // R9: receive routing sweep over every code
        for (int j = 0; j < NR; j++) begin
            for (int c = 1; c <= 31; c++) begin
                wr(8'(RXB + j), {5'(c), 3'b111});
                erx[j] = 5'(c);
                rd(8'(RXB + j), v);
                chk("R9 rx readback", v, {erx[j], 3'b000});
                chk("R9 rx route", rx_out[j], exp_rx(j));
            end
        end
        wr(8'(RXB + 2), {5'd3, 3'b000});
        erx[2] = 5'd3;
        wr(8'(RXB + 2), 8'h07);
        rd(8'(RXB + 2), v);
        chk("R9 rx keep", v, 8'h18);
        chk("R9 rx keep route", rx_out[2], pad_in[2]);

        // R10: unmapped addresses
        for (int a = 0; a < 256; a++) begin
            if (!(a < NP || a == SWA || (a >= RXB && a < RXB + NR))) begin
                wr(8'(a), 8'hFF);
                rd(8'(a), v);
                chk("R10 unmapped read", v, 8'h00);
            end
        end
        chk_all("R10 no side effect");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule